// File: doc/BRIEF.md
# Shared Packet Buffer Partition Manager

This block partitions a 128 KB packet store among eight sockets. The store is made of sixteen blocks of 8 KB. Software sets two sizes for each socket, one for transmit and one for receive, in units of 1 KB. It also sets a 16-bit block-type map, where a 1 in a bit makes that 8 KB block part of the transmit region and a 0 makes it part of the receive region. The transmit blocks sit at the bottom of the store, so the receive region starts directly after the last transmit block.

From this configuration the block checks each direction for consistency. It gives one valid flag per direction, and a traffic engine must not move data in a direction whose flag is low. The block also gives the start offset of every socket's buffer, in KB, found by running sums over the socket sizes. A two-state machine tracks pending configuration writes. The state `ST_UPDATE` means that a write has landed and the results must be captured. The state `ST_STABLE` means that the registered results match the stored configuration. The transitions are as follows:
- A write in any state leads to `ST_UPDATE`.
- A cycle in `ST_UPDATE` without a write leads to `ST_STABLE`.
- A cycle in `ST_STABLE` without a write stays in `ST_STABLE`.

Reset enters `ST_UPDATE`, so the default configuration is evaluated on the first clock after reset.

Top module: `buf_part_mgr`

## Requirements
- R1: After reset, every socket size register reads back 8 and the type map reads back 0x00FF.
- R2: Register map: address 0..7 holds the TX size of socket `addr`, address 8..15 holds the RX size of socket `addr-8`, and address 16 holds the type map. A size write keeps `cfg_wdata[6:0]`, and a map write keeps `cfg_wdata[15:0]`. Readback is zero-extended. A write to any other address changes nothing, and a read of any other address returns 0.
- R3: The valid flags and base offsets reflect a write one clock edge after the edge that stores it, and they do not change while no write occurs.
- R4: The TX base of socket n, on bits `n*11 +: 11` of `tx_base_o`, equals the sum of the TX sizes of sockets 0..n-1, in KB.
- R5: The RX base of socket n, on bits `n*11 +: 11` of `rx_base_o`, equals 8 times the number of 1 bits in the map, plus the sum of the RX sizes of sockets 0..n-1.
- R6: TX valid requires the sum of the TX sizes to be a multiple of 8. RX valid requires the same of the RX sum.
- R7: When the TX sum plus the RX sum exceeds 128, both valid flags are low.
- R8: When the 1 bits of the map do not form one unbroken run starting at bit 0, both valid flags are low.
- R9: TX valid requires the TX sum to equal 8 times the number of 1 bits in the map. RX valid requires the RX sum to equal 8 times the number of 0 bits. An all-zero map with 128 KB of RX is valid.
- R10: A size above 64 in one direction lowers the valid flag of that direction only.
- R11: With the reset configuration, both valid flags are high, the TX bases are 0,8,..,56 and the RX bases are 64,72,..,120.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Register address for write and read |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Combinational readback of the addressed register |
| tx_valid_o | output | 1 | TX configuration consistent |
| rx_valid_o | output | 1 | RX configuration consistent |
| tx_base_o | output | 88 | Eight 11-bit TX start offsets in KB |
| rx_base_o | output | 88 | Eight 11-bit RX start offsets in KB |

## Verification
A register write takes effect on the rising edge that samples `cfg_we`. Readback through `cfg_rdata` follows combinationally, so the bench reads it a moment after it sets the address. The valid flags and bases are captured on the next rising edge. The bench therefore samples them one falling edge after the write edge, where they must still hold the old values, and then again one edge later, where they must show the new result. Each check compares against a model of the rules that the bench evaluates itself.

// File: rtl/bp_pkg.sv
package bp_pkg;
    typedef enum logic [0:0] {
        ST_UPDATE = 1'b0,
        ST_STABLE = 1'b1
    } bp_state_e;
endpackage

// File: rtl/bp_cfg_regs.sv
module bp_cfg_regs #(
    parameter int NUM_SOCK = 8,
    parameter int NUM_BLK  = 16,
    parameter int SIZE_W   = 7,
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 5,
    parameter int DFLT_KB  = 8,
    parameter logic [NUM_BLK-1:0] DFLT_MAP = 16'h00FF
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    output logic [NUM_SOCK*SIZE_W-1:0] tx_size,
    output logic [NUM_SOCK*SIZE_W-1:0] rx_size,
    output logic [NUM_BLK-1:0]         type_map
);
    localparam int RX_OFS   = NUM_SOCK;
    localparam int MAP_ADDR = 2 * NUM_SOCK;

    logic [SIZE_W-1:0] tx_q [NUM_SOCK];
    logic [SIZE_W-1:0] rx_q [NUM_SOCK];
    logic [NUM_BLK-1:0] map_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SOCK; s++) begin
                tx_q[s] <= SIZE_W'(DFLT_KB);
                rx_q[s] <= SIZE_W'(DFLT_KB);
            end
            map_q <= DFLT_MAP;
        end else if (we) begin
            for (int s = 0; s < NUM_SOCK; s++) begin
                if (addr == ADDR_W'(s))          tx_q[s] <= wdata[SIZE_W-1:0];
                if (addr == ADDR_W'(RX_OFS + s)) rx_q[s] <= wdata[SIZE_W-1:0];
            end
            if (addr == ADDR_W'(MAP_ADDR)) map_q <= wdata[NUM_BLK-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        for (int s = 0; s < NUM_SOCK; s++) begin
            if (addr == ADDR_W'(s))          rdata = DATA_W'(tx_q[s]);
            if (addr == ADDR_W'(RX_OFS + s)) rdata = DATA_W'(rx_q[s]);
        end
        if (addr == ADDR_W'(MAP_ADDR)) rdata = DATA_W'(map_q);
    end

    for (genvar s = 0; s < NUM_SOCK; s++) begin : g_flat
        assign tx_size[s*SIZE_W +: SIZE_W] = tx_q[s];
        assign rx_size[s*SIZE_W +: SIZE_W] = rx_q[s];
    end
    assign type_map = map_q;
endmodule

// File: rtl/bp_prefix.sv
module bp_prefix #(
    parameter int NUM_SOCK = 8,
    parameter int SIZE_W   = 7,
    parameter int SUM_W    = 11,
    parameter int MAX_KB   = 64
) (
    input  logic [NUM_SOCK*SIZE_W-1:0] sizes,
    input  logic [SUM_W-1:0]           start,
    output logic [NUM_SOCK*SUM_W-1:0]  bases,
    output logic [SUM_W-1:0]           total,
    output logic                       oversize
);
    logic [SUM_W-1:0] acc;

    always_comb begin
        acc      = '0;
        oversize = 1'b0;
        bases    = '0;
        for (int s = 0; s < NUM_SOCK; s++) begin
            bases[s*SUM_W +: SUM_W] = start + acc;
            acc = acc + SUM_W'(sizes[s*SIZE_W +: SIZE_W]);
            if (sizes[s*SIZE_W +: SIZE_W] > SIZE_W'(MAX_KB)) oversize = 1'b1;
        end
    end

    assign total = acc;
endmodule

// File: rtl/bp_rules.sv
module bp_rules #(
    parameter int NUM_BLK  = 16,
    parameter int BLK_KB   = 8,
    parameter int SUM_W    = 11,
    parameter int TOTAL_KB = 128
) (
    input  logic [NUM_BLK-1:0] type_map,
    input  logic [SUM_W-1:0]   tx_total,
    input  logic [SUM_W-1:0]   rx_total,
    input  logic               tx_over,
    input  logic               rx_over,
    output logic               tx_ok,
    output logic               rx_ok,
    output logic [SUM_W-1:0]   rx_start
);
    localparam int CNT_W = $clog2(NUM_BLK + 1);

    logic [CNT_W-1:0] tx_blocks;
    logic [CNT_W-1:0] rx_blocks;
    logic             contig;
    logic             fits;
    logic             tx_aligned;
    logic             rx_aligned;
    logic             tx_match;
    logic             rx_match;

    assign tx_blocks  = CNT_W'($countones(type_map));
    assign rx_blocks  = CNT_W'(NUM_BLK) - tx_blocks;
    assign contig     = ((type_map & (type_map + NUM_BLK'(1))) == '0);
    assign fits       = ({1'b0, tx_total} + {1'b0, rx_total}) <= (SUM_W+1)'(TOTAL_KB);
    assign tx_aligned = (tx_total % SUM_W'(BLK_KB)) == '0;
    assign rx_aligned = (rx_total % SUM_W'(BLK_KB)) == '0;
    assign tx_match   = tx_total == SUM_W'(tx_blocks) * SUM_W'(BLK_KB);
    assign rx_match   = rx_total == SUM_W'(rx_blocks) * SUM_W'(BLK_KB);
    assign rx_start   = SUM_W'(tx_blocks) * SUM_W'(BLK_KB);

    assign tx_ok = contig && fits && tx_aligned && tx_match && !tx_over;
    assign rx_ok = contig && fits && rx_aligned && rx_match && !rx_over;
endmodule

// File: rtl/buf_part_mgr.sv
module buf_part_mgr
    import bp_pkg::*;
#(
    parameter int NUM_SOCK = 8,
    parameter int NUM_BLK  = 16,
    parameter int BLK_KB   = 8,
    parameter int SIZE_W   = 7,
    parameter int MAX_KB   = 64,
    parameter int DFLT_KB  = 8,
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 5,
    parameter int SUM_W    = $clog2(NUM_SOCK*((1 << SIZE_W) - 1) + NUM_BLK*BLK_KB + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [ADDR_W-1:0]         cfg_addr,
    input  logic [DATA_W-1:0]         cfg_wdata,
    output logic [DATA_W-1:0]         cfg_rdata,
    output logic                      tx_valid_o,
    output logic                      rx_valid_o,
    output logic [NUM_SOCK*SUM_W-1:0] tx_base_o,
    output logic [NUM_SOCK*SUM_W-1:0] rx_base_o
);
    localparam int TOTAL_KB = NUM_BLK * BLK_KB;
    localparam int DFLT_BLK = (NUM_SOCK * DFLT_KB) / BLK_KB;
    localparam logic [NUM_BLK-1:0] DFLT_MAP = NUM_BLK'((64'(1) << DFLT_BLK) - 64'(1));

    logic [NUM_SOCK*SIZE_W-1:0] tx_size;
    logic [NUM_SOCK*SIZE_W-1:0] rx_size;
    logic [NUM_BLK-1:0]         type_map;
    logic [NUM_SOCK*SUM_W-1:0]  tx_base_c;
    logic [NUM_SOCK*SUM_W-1:0]  rx_base_c;
    logic [SUM_W-1:0]           tx_total;
    logic [SUM_W-1:0]           rx_total;
    logic [SUM_W-1:0]           rx_start;
    logic                       tx_over;
    logic                       rx_over;
    logic                       tx_ok;
    logic                       rx_ok;
    bp_state_e                  state_q;
    bp_state_e                  state_d;

    bp_cfg_regs #(
        .NUM_SOCK(NUM_SOCK), .NUM_BLK(NUM_BLK), .SIZE_W(SIZE_W), .DATA_W(DATA_W),
        .ADDR_W(ADDR_W), .DFLT_KB(DFLT_KB), .DFLT_MAP(DFLT_MAP)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .rdata(cfg_rdata), .tx_size(tx_size), .rx_size(rx_size), .type_map(type_map)
    );

    bp_prefix #(.NUM_SOCK(NUM_SOCK), .SIZE_W(SIZE_W), .SUM_W(SUM_W), .MAX_KB(MAX_KB)) u_tx_sum (
        .sizes(tx_size), .start('0), .bases(tx_base_c), .total(tx_total), .oversize(tx_over)
    );

    bp_prefix #(.NUM_SOCK(NUM_SOCK), .SIZE_W(SIZE_W), .SUM_W(SUM_W), .MAX_KB(MAX_KB)) u_rx_sum (
        .sizes(rx_size), .start(rx_start), .bases(rx_base_c), .total(rx_total), .oversize(rx_over)
    );

    bp_rules #(.NUM_BLK(NUM_BLK), .BLK_KB(BLK_KB), .SUM_W(SUM_W), .TOTAL_KB(TOTAL_KB)) u_rules (
        .type_map(type_map), .tx_total(tx_total), .rx_total(rx_total),
        .tx_over(tx_over), .rx_over(rx_over), .tx_ok(tx_ok), .rx_ok(rx_ok), .rx_start(rx_start)
    );

    always_comb begin
        unique case (state_q)
            ST_UPDATE: state_d = cfg_we ? ST_UPDATE : ST_STABLE;
            ST_STABLE: state_d = cfg_we ? ST_UPDATE : ST_STABLE;
            default:   state_d = ST_UPDATE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_UPDATE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_valid_o <= 1'b0;
            rx_valid_o <= 1'b0;
            tx_base_o  <= '0;
            rx_base_o  <= '0;
        end else if (state_q == ST_UPDATE) begin
            tx_valid_o <= tx_ok;
            rx_valid_o <= rx_ok;
            tx_base_o  <= tx_base_c;
            rx_base_o  <= rx_base_c;
        end
    end
endmodule

// File: rtl/bp_checker.sv
module bp_checker
    import bp_pkg::*;
#(
    parameter int NUM_SOCK = 8,
    parameter int NUM_BLK  = 16,
    parameter int BLK_KB   = 8,
    parameter int SUM_W    = 11
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cfg_we,
    input bp_state_e                 state_q,
    input logic [NUM_BLK-1:0]        type_map,
    input logic [SUM_W-1:0]          tx_total,
    input logic [SUM_W-1:0]          rx_total,
    input logic                      tx_valid_o,
    input logic                      rx_valid_o,
    input logic [NUM_SOCK*SUM_W-1:0] tx_base_o,
    input logic [NUM_SOCK*SUM_W-1:0] rx_base_o
);
    localparam int TOTAL_KB = NUM_BLK * BLK_KB;

    AST_WRITE_ARMS_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (state_q == ST_UPDATE)); // R3

    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STABLE) |=> ($stable(tx_valid_o) && $stable(rx_valid_o)
                                    && $stable(tx_base_o) && $stable(rx_base_o))); // R3

    AST_TX_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STABLE && tx_valid_o) |-> ((int'(tx_total) % BLK_KB) == 0)); // R6

    AST_TOTAL_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STABLE && (tx_valid_o || rx_valid_o))
            |-> ((int'(tx_total) + int'(rx_total)) <= TOTAL_KB)); // R7

    AST_MAP_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STABLE && ((type_map & (type_map + NUM_BLK'(1))) != '0))
            |-> (!tx_valid_o && !rx_valid_o)); // R8

    AST_TX_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STABLE && tx_valid_o)
            |-> (int'(tx_total) == BLK_KB * $countones(type_map))); // R9

    AST_RX_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STABLE && rx_valid_o)
            |-> (int'(rx_total) == BLK_KB * (NUM_BLK - $countones(type_map)))); // R9
endmodule

bind buf_part_mgr bp_checker #(
    .NUM_SOCK(NUM_SOCK), .NUM_BLK(NUM_BLK), .BLK_KB(BLK_KB), .SUM_W(SUM_W)
) u_bp_checker (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .state_q(state_q), .type_map(type_map),
    .tx_total(tx_total), .rx_total(rx_total), .tx_valid_o(tx_valid_o),
    .rx_valid_o(rx_valid_o), .tx_base_o(tx_base_o), .rx_base_o(rx_base_o)
);

// File: tb/test_buf_part_mgr.sv
`timescale 1ns/1ps
module test_buf_part_mgr;
    localparam int NS = 8;
    localparam int BW = 11;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_we = 1'b0;
    logic [4:0]     cfg_addr = '0;
    logic [15:0]    cfg_wdata = '0;
    logic [15:0]    cfg_rdata;
    logic           tx_valid_o;
    logic           rx_valid_o;
    logic [NS*BW-1:0] tx_base_o;
    logic [NS*BW-1:0] rx_base_o;

    int n_checks = 0;
    int n_fail   = 0;
    int txm [NS];
    int rxm [NS];
    int mapm;

    always #4 clk = ~clk;

    buf_part_mgr i_buf_part_mgr (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .tx_valid_o(tx_valid_o),
        .rx_valid_o(rx_valid_o), .tx_base_o(tx_base_o), .rx_base_o(rx_base_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Write one register at a falling edge; returns just after the storing edge.
    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 16'(d);
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < NS)          txm[a] = d & 127;
        else if (a < 2*NS)   rxm[a-NS] = d & 127;
        else if (a == 2*NS)  mapm = d & 16'hFFFF;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic rd_check(input int a, input int exp, input string req);
        cfg_addr = 5'(a);
        #1;
        check(int'(cfg_rdata) == exp, req, int'(cfg_rdata), exp);
    endtask

    // Compare outputs against the rule model.
    task automatic check_model(input string req);
        int ts, rs, ones, acc;
        bit contig, tover, rover, etx, erx;
        ts = 0; rs = 0; tover = 0; rover = 0;
        for (int s = 0; s < NS; s++) begin
            ts += txm[s]; rs += rxm[s];
            if (txm[s] > 64) tover = 1;
            if (rxm[s] > 64) rover = 1;
        end
        ones = $countones(mapm[15:0]);
        contig = ((mapm & (mapm + 1)) & 16'hFFFF) == 0;
        etx = !tover && (ts % 8 == 0) && (ts + rs <= 128) && contig && (ts == 8*ones);
        erx = !rover && (rs % 8 == 0) && (ts + rs <= 128) && contig && (rs == 8*(16-ones));
        check(tx_valid_o == etx, {req, " tx_valid"}, tx_valid_o, etx);
        check(rx_valid_o == erx, {req, " rx_valid"}, rx_valid_o, erx);
        acc = 0;
        for (int s = 0; s < NS; s++) begin
            check(int'(tx_base_o[s*BW +: BW]) == acc, {req, " R4 tx_base"}, int'(tx_base_o[s*BW +: BW]), acc);
            acc += txm[s];
        end
        acc = 8*ones;
        for (int s = 0; s < NS; s++) begin
            check(int'(rx_base_o[s*BW +: BW]) == acc, {req, " R5 rx_base"}, int'(rx_base_o[s*BW +: BW]), acc);
            acc += rxm[s];
        end
    endtask

    task automatic load_defaults();
        for (int s = 0; s < NS; s++) begin wr(s, 8); wr(NS+s, 8); end
        wr(2*NS, 16'h00FF);
        settle();
    endtask

    task automatic t_reset();
        for (int s = 0; s < NS; s++) begin
            rd_check(s, 8, "R1 tx size reset");
            rd_check(NS+s, 8, "R1 rx size reset");
        end
        rd_check(2*NS, 16'h00FF, "R1 map reset");
        check(tx_valid_o && rx_valid_o, "R11 defaults valid", int'({tx_valid_o, rx_valid_o}), 3);
        check_model("R11 default bases");
    endtask

    task automatic t_regmap();
        wr(2, 16'hFF88);
        rd_check(2, 8, "R2 size field masked");
        wr(NS+3, 5);
        rd_check(NS+3, 5, "R2 rx address");
        wr(20, 16'h1234);
        rd_check(20, 0, "R2 unmapped read");
        for (int s = 0; s < NS; s++) rd_check(s, txm[s], "R2 unmapped write no effect");
        rd_check(2*NS, 16'h00FF, "R2 map untouched");
        load_defaults();
        check_model("R2 after restore");
    endtask

    task automatic t_timing();
        wr(0, 9);
        check(tx_valid_o == 1'b1, "R3 old value one edge after write", tx_valid_o, 1);
        check(rx_valid_o == 1'b1, "R3 old rx value held", rx_valid_o, 1);
        settle();
        check(tx_valid_o == 1'b0, "R3 R6 tx update after capture", tx_valid_o, 0);
        check(rx_valid_o == 1'b0, "R3 R7 rx update after capture", rx_valid_o, 0);
        repeat (3) settle();
        check_model("R3 held without writes");
        load_defaults();
    endtask

    task automatic t_uneven();
        int tv [NS] = '{16, 8, 8, 4, 4, 8, 8, 8};
        int rv [NS] = '{1, 7, 8, 8, 8, 8, 8, 16};
        for (int s = 0; s < NS; s++) begin wr(s, tv[s]); wr(NS+s, rv[s]); end
        settle();
        check(tx_valid_o && rx_valid_o, "R6 uneven sums aligned", int'({tx_valid_o, rx_valid_o}), 3);
        check_model("R4 R5 uneven");
        load_defaults();
    endtask

    task automatic t_total();
        wr(NS+7, 16);
        settle();
        check(tx_valid_o == 1'b0, "R7 tx cleared by overflow", tx_valid_o, 0);
        check_model("R7 overflow");
        load_defaults();
    endtask

    task automatic t_contig();
        wr(2*NS, 16'h01FE);
        settle();
        check(!tx_valid_o && !rx_valid_o, "R8 broken run", int'({tx_valid_o, rx_valid_o}), 0);
        check_model("R8 broken run");
        load_defaults();
    endtask

    task automatic t_count();
        wr(2*NS, 16'h0FFF);
        settle();
        check(!tx_valid_o && !rx_valid_o, "R9 count mismatch", int'({tx_valid_o, rx_valid_o}), 0);
        for (int s = 0; s < NS; s++) begin wr(s, 12); wr(NS+s, 4); end
        settle();
        check(tx_valid_o && rx_valid_o, "R9 count match", int'({tx_valid_o, rx_valid_o}), 3);
        check(int'(rx_base_o[0 +: BW]) == 96, "R5 rx start after 12 blocks", int'(rx_base_o[0 +: BW]), 96);
        check_model("R9 twelve tx blocks");
        load_defaults();
    endtask

    task automatic t_oversize();
        wr(2*NS, 16'h01FF);
        for (int s = 0; s < NS; s++) begin wr(s, 0); wr(NS+s, 0); end
        wr(0, 72);
        wr(NS, 56);
        settle();
        check(tx_valid_o == 1'b0, "R10 tx oversize", tx_valid_o, 0);
        check(rx_valid_o == 1'b1, "R10 rx unaffected", rx_valid_o, 1);
        check_model("R10 oversize");
        wr(0, 64);
        wr(1, 8);
        settle();
        check(tx_valid_o && rx_valid_o, "R10 split fixes", int'({tx_valid_o, rx_valid_o}), 3);
        check_model("R10 split");
        load_defaults();
    endtask

    task automatic t_allrx();
        wr(2*NS, 0);
        for (int s = 0; s < NS; s++) begin wr(s, 0); wr(NS+s, 16); end
        settle();
        check(tx_valid_o && rx_valid_o, "R9 all rx map", int'({tx_valid_o, rx_valid_o}), 3);
        check_model("R5 all rx");
        load_defaults();
    endtask

    initial begin
        for (int s = 0; s < NS; s++) begin txm[s] = 8; rxm[s] = 8; end
        mapm = 16'h00FF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_regmap();
        t_timing();
        t_uneven();
        t_total();
        t_contig();
        t_count();
        t_oversize();
        t_allrx();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule